// File: doc/BRIEF.md
# Serial Flash Status Protection Logic

This block keeps the protection portion of a serial flash status register: a status-register lock bit, a three-bit block-protect field and the volatile write-enable latch. A command front-end hands it already decoded, single-cycle strobes: write enable, write disable, write status with a data byte, and chip erase. The block also receives the raw write-protect pin, which is active low. For each strobe it decides whether the request is carried out. It then updates its bits and raises a one-cycle accept or reject flag on the next clock.

A status write is gated by the lock bit together with the write-protect pin. With the lock bit clear, the write-enable latch alone governs a status write. With the lock bit set and the pin high, status writes are still possible after a write enable. With the lock bit set and the pin low, the lock bit and the protect field cannot be changed. A chip erase goes ahead only when write enable is set and every block-protect bit is zero.

Top module: `sfp_protect_top`

## Requirements
- R1: After reset the lock bit, the protect field, the write-enable latch and all four result flags read 0.
- R2: A write-enable strobe sets the write-enable latch and a write-disable strobe clears it. Each takes effect on the clock edge that samples it.
- R3: An accepted status write loads the lock bit from data bit 7 and the protect field from data bits 4:2, with bit 4 going to the top protect bit. It ignores data bits 6:5 and 1:0, clears the write-enable latch and pulses the status-write accept flag.
- R4: A status write that arrives while the write-enable latch is 0 is rejected. The lock bit, the protect field and the latch stay as they were, and the status-write reject flag pulses.
- R5: While the lock bit is 1 and the synchronised write-protect level is low, a status write is rejected even with the write-enable latch at 1. The lock bit and protect field stay frozen, and the latch keeps its value.
- R6: While the lock bit is 0, a status write with the write-enable latch at 1 is accepted whatever the write-protect level.
- R7: A chip erase is accepted only when the write-enable latch is 1 and the protect field is 0. Acceptance clears the latch and pulses the erase accept flag. An erase with the latch at 0 pulses the erase reject flag.
- R8: A chip erase with a nonzero protect field is rejected. The write-enable latch keeps its value and the erase reject flag pulses.
- R9: The write-protect pin passes through two flip-flops. A level first captured at a rising edge governs status writes from the second rising edge after that one.
- R10: When several strobes coincide, the status write wins over chip erase, chip erase over write disable, and write disable over write enable. The losing strobes have no effect.
- R11: The result flags are registered and appear in the cycle after the strobe. Each flag is high for exactly one cycle per request, and a request never raises both its accept and its reject flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low, released synchronously inside |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| chip_erase_i | input | 1 | Chip-erase request strobe |
| wp_ni | input | 1 | Write-protect pin, active low, asynchronous |
| srp_o | output | 1 | Status-register lock bit |
| bp_o | output | 3 | Block-protect field |
| wel_o | output | 1 | Write-enable latch |
| wrsr_accept_o | output | 1 | Status write carried out |
| wrsr_reject_o | output | 1 | Status write refused |
| ce_accept_o | output | 1 | Chip erase allowed |
| ce_reject_o | output | 1 | Chip erase refused |

## Verification
The situation hardest to reach from the ports is a status write issued while a new write-protect level is still moving through the synchroniser. Here the decision must follow the old level for exactly two more sampling edges. The stimulus first locks the register with the pin low. It then raises the pin and fires status writes on three back-to-back cycles, expecting reject, reject, accept. The scoreboard model tracks its own two-stage copy of the pin, so every decision is predicted at the exact edge.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int DATA_W  = 8;
  localparam int BP_W    = 3;
  localparam int SRP_BIT = 7;
  localparam int BP_LSB  = 2;

  typedef struct packed {
    logic            srp;
    logic [BP_W-1:0] bp;
  } prot_t;

  typedef enum logic [2:0] {
    REQ_NONE = 3'd0,
    REQ_WRSR = 3'd1,
    REQ_CE   = 3'd2,
    REQ_WRDI = 3'd3,
    REQ_WREN = 3'd4
  } req_e;
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sfp_guard.sv
module sfp_guard
  import sfp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wren_i,
  input  logic  wrdi_i,
  input  logic  wrsr_i,
  input  logic  ce_i,
  input  prot_t cur_i,
  input  logic  wel_i,
  input  logic  wp_sync_i,
  output req_e  sel_o,
  output logic  wrsr_ok_o,
  output logic  ce_ok_o,
  output logic  wrsr_acc_o,
  output logic  wrsr_rej_o,
  output logic  ce_acc_o,
  output logic  ce_rej_o
);
  req_e sel;
  logic wr_lock;
  logic wrsr_ok, ce_ok;
  logic wa_d, wr_d, ca_d, cr_d;
  logic wa_q, wr_q, ca_q, cr_q;

  // priority resolution of coinciding strobes
  always_comb begin
    if      (wrsr_i) sel = REQ_WRSR;
    else if (ce_i)   sel = REQ_CE;
    else if (wrdi_i) sel = REQ_WRDI;
    else if (wren_i) sel = REQ_WREN;
    else             sel = REQ_NONE;
  end

  always_comb begin
    wr_lock = cur_i.srp & ~wp_sync_i;
    wrsr_ok = (sel == REQ_WRSR) & wel_i & ~wr_lock;
    ce_ok   = (sel == REQ_CE) & wel_i & (cur_i.bp == '0);
    wa_d    = wrsr_ok;
    wr_d    = (sel == REQ_WRSR) & ~wrsr_ok;
    ca_d    = ce_ok;
    cr_d    = (sel == REQ_CE) & ~ce_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_q <= 1'b0;
      wr_q <= 1'b0;
      ca_q <= 1'b0;
      cr_q <= 1'b0;
    end else begin
      wa_q <= wa_d;
      wr_q <= wr_d;
      ca_q <= ca_d;
      cr_q <= cr_d;
    end
  end

  assign sel_o      = sel;
  assign wrsr_ok_o  = wrsr_ok;
  assign ce_ok_o    = ce_ok;
  assign wrsr_acc_o = wa_q;
  assign wrsr_rej_o = wr_q;
  assign ce_acc_o   = ca_q;
  assign ce_rej_o   = cr_q;

  AST_LOCK_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrsr_i && cur_i.srp && !wp_sync_i) |=> (wr_q && !wa_q)); // R5
  AST_CE_BP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == REQ_CE && cur_i.bp != '0) |=> (cr_q && !ca_q)); // R8
  AST_NO_REQ_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrsr_i && !ce_i) |=> !(wa_q || wr_q || ca_q || cr_q)); // R11
endmodule

// File: rtl/sfp_wel_ctrl.sv
module sfp_wel_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_q, wel_d, wel_en;

  always_comb begin
    wel_en = set_i | clr_i;
    wel_d  = clr_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end

  assign wel_o = wel_q;

  AST_WEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> wel_q); // R2
  AST_WEL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !wel_q); // R2
  AST_WEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(wel_q)); // R4
endmodule

// File: rtl/sfp_stat_regs.sv
module sfp_stat_regs
  import sfp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output prot_t             prot_o
);
  prot_t prot_q, prot_d;

  always_comb prot_d.srp = data_i[SRP_BIT];

  generate
    for (genvar k = 0; k < BP_W; k++) begin : g_bp
      always_comb prot_d.bp[k] = data_i[BP_LSB + k];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prot_q <= '0;
    else if (load_i) prot_q <= prot_d;
  end

  assign prot_o = prot_q;

  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(prot_q)); // R4
endmodule

// File: rtl/sfp_protect_top.sv
module sfp_protect_top
  import sfp_pkg::*;
#(
  parameter int WP_STAGES  = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [DATA_W-1:0] wrsr_data_i,
  input  logic              chip_erase_i,
  input  logic              wp_ni,
  output logic              srp_o,
  output logic [BP_W-1:0]   bp_o,
  output logic              wel_o,
  output logic              wrsr_accept_o,
  output logic              wrsr_reject_o,
  output logic              ce_accept_o,
  output logic              ce_reject_o
);
  logic  rst_sync_n;
  logic  wp_sync;
  req_e  sel;
  logic  wrsr_ok, ce_ok;
  logic  wel;
  prot_t prot;
  logic  wel_set, wel_clr;

  sfp_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  sfp_sync #(.STAGES(WP_STAGES), .RST_VAL(1'b0)) u_wp_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   (wp_ni),
    .q_o   (wp_sync)
  );

  sfp_guard u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wren_i    (wren_i),
    .wrdi_i    (wrdi_i),
    .wrsr_i    (wrsr_i),
    .ce_i      (chip_erase_i),
    .cur_i     (prot),
    .wel_i     (wel),
    .wp_sync_i (wp_sync),
    .sel_o     (sel),
    .wrsr_ok_o (wrsr_ok),
    .ce_ok_o   (ce_ok),
    .wrsr_acc_o(wrsr_accept_o),
    .wrsr_rej_o(wrsr_reject_o),
    .ce_acc_o  (ce_accept_o),
    .ce_rej_o  (ce_reject_o)
  );

  always_comb begin
    wel_set = (sel == REQ_WREN);
    wel_clr = (sel == REQ_WRDI) | wrsr_ok | ce_ok;
  end

  sfp_wel_ctrl u_wel (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .set_i (wel_set),
    .clr_i (wel_clr),
    .wel_o (wel)
  );

  sfp_stat_regs u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .load_i(wrsr_ok),
    .data_i(wrsr_data_i),
    .prot_o(prot)
  );

  assign srp_o = prot.srp;
  assign bp_o  = prot.bp;
  assign wel_o = wel;

  AST_HWP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (srp_o && !wp_sync) |=> ($stable(srp_o) && $stable(bp_o))); // R5
  AST_ACCEPT_CLEARS_WEL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wrsr_accept_o || ce_accept_o) |-> !wel_o); // R3
  AST_REJECT_KEEPS_PROT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    wrsr_reject_o |-> ($stable(srp_o) && $stable(bp_o))); // R4
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !(wrsr_accept_o && wrsr_reject_o) && !(ce_accept_o && ce_reject_o)); // R11
endmodule

// File: tb/tb_sfp_protect_top.sv
`timescale 1ns/1ps
module tb_sfp_protect_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wren, wrdi, wrsr, ce, wp_n;
  logic [7:0] wdata;
  logic       srp, wel, wa, wr, ca, cr;
  logic [2:0] bp;

  typedef struct {
    logic [9:0] val;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic done = 1'b0;

  // model state
  logic       m_srp, m_wel, m_s1, m_s2, wp_pin;
  logic [2:0] m_bp;

  always #2 clk = ~clk;

  sfp_protect_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_data_i(wdata), .chip_erase_i(ce), .wp_ni(wp_n),
    .srp_o(srp), .bp_o(bp), .wel_o(wel), .wrsr_accept_o(wa),
    .wrsr_reject_o(wr), .ce_accept_o(ca), .ce_reject_o(cr)
  );

  // one call = one clock cycle of stimulus, expected result queued
  task automatic issue(input logic en, input logic di, input logic sr,
                       input logic [7:0] d, input logic er, input string tag);
    logic eff;
    logic fa, fr, fca, fcr;
    exp_t e;
    @(negedge clk);
    wren = en; wrdi = di; wrsr = sr; wdata = d; ce = er; wp_n = wp_pin;
    eff = m_s2; m_s2 = m_s1; m_s1 = wp_pin;
    fa = 0; fr = 0; fca = 0; fcr = 0;
    if (sr) begin
      if (m_wel && !(m_srp && !eff)) begin
        m_srp = d[7]; m_bp = d[4:2]; m_wel = 0; fa = 1;
      end else fr = 1;
    end else if (er) begin
      if (m_wel && m_bp == 3'b000) begin m_wel = 0; fca = 1; end
      else fcr = 1;
    end else if (di) m_wel = 0;
    else if (en) m_wel = 1;
    e.val = {m_srp, m_bp, m_wel, fa, fr, fca, fcr, 1'b0};
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic nop(input string tag);
    issue(0, 0, 0, 8'h00, 0, tag);
  endtask

  // monitor: compares each queued item one edge after its stimulus
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [9:0] act;
      e = exp_q.pop_front();
      act = {srp, bp, wel, wa, wr, ca, cr, 1'b0};
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s: actual %b expected %b", e.tag, act, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wren = 0; wrdi = 0; wrsr = 0; ce = 0; wdata = 0;
    wp_pin = 1; wp_n = 1;
    m_srp = 0; m_bp = 0; m_wel = 0; m_s1 = 0; m_s2 = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if ({srp, bp, wel, wa, wr, ca, cr} !== 9'b0) begin
      errors++;
      $display("FAIL R1: actual %b expected %b", {srp, bp, wel, wa, wr, ca, cr}, 9'b0);
    end
    rst_n = 1;
    repeat (6) nop("R1");

    issue(1, 0, 0, 8'h00, 0, "R2");       // set WEL
    issue(0, 1, 0, 8'h00, 0, "R2");       // clear WEL
    issue(1, 1, 0, 8'h00, 0, "R10");      // disable beats enable
    issue(0, 0, 1, 8'h9C, 0, "R4");       // WEL=0 -> reject
    nop("R11");                           // reject pulse gone
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(0, 0, 1, 8'h7F, 0, "R3");       // srp=0 bp=111, other bits ignored
    nop("R11");
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(0, 0, 0, 8'h00, 1, "R8");       // bp!=0 -> reject, WEL kept
    issue(0, 0, 1, 8'h00, 0, "R3");       // clear bp
    issue(0, 0, 0, 8'h00, 1, "R7");       // WEL=0 -> reject
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(0, 0, 0, 8'h00, 1, "R7");       // accepted
    // SRP=0 with pin low: still writable
    wp_pin = 0;
    repeat (3) nop("R6");
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(0, 0, 1, 8'h88, 0, "R6");       // srp=1 bp=010
    // hardware protected
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(0, 0, 1, 8'h00, 0, "R5");       // reject, WEL stays 1
    nop("R5");
    // raise pin: two more rejects, then accept
    wp_pin = 1;
    issue(0, 0, 1, 8'h00, 0, "R9");
    issue(0, 0, 1, 8'h00, 0, "R9");
    issue(0, 0, 1, 8'h00, 0, "R9");
    // priority
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(1, 0, 1, 8'h10, 1, "R10");      // status write wins
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(0, 0, 0, 8'h00, 1, "R8");       // bp=100 blocks erase
    issue(0, 0, 1, 8'h00, 0, "R3");
    issue(1, 0, 0, 8'h00, 0, "R2");
    issue(1, 1, 0, 8'h00, 1, "R10");      // erase wins over disable/enable
    nop("R11");
    nop("R11");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule